// File: doc/BRIEF.md
# Counter-Ramp Analog-to-Digital Conversion Controller

This block sequences a counter-type analog-to-digital converter. An external DAC takes the block's counter value, and an external comparator returns one bit saying whether the DAC output has reached the analog input. When the host asks for a conversion, the counter restarts at zero and climbs by one each clock. It stops when the comparator trips or when it reaches full scale. The count at that moment becomes the result.

The host sees one status line. It is low while a conversion runs and high when the result is ready. The host then fetches the result a byte at a time through two byte-enable inputs. Conversion time depends on the data, from a single busy cycle for a zero input up to 2^N busy cycles at full scale. The resolution N is a parameter from 8 to 16 bits.

Top module: `ramp_adc_ctrl`

## Requirements
- R1: After reset `convDone` is 1, `dacCode` is 0 and the stored result is 0, so a low-byte read returns 0.
- R2: With `convDone` at 1, a `startReq` sampled high at a rising edge makes `convDone` 0 and `dacCode` 0 after that edge.
- R3: While `convDone` is 0, the comparator is low and `dacCode` is not all ones, `dacCode` rises by exactly one at each rising edge.
- R4: When `cmpHigh` is 1 in a busy cycle, the result becomes the `dacCode` of that cycle and `convDone` returns to 1 after that edge.
- R5: If `dacCode` reaches all ones without the comparator tripping, the conversion ends with the all-ones result after 2^N busy cycles.
- R6: A `startReq` that arrives while `convDone` is 0 is ignored: the ramp continues, and neither the result nor the duration changes.
- R7: A conversion whose comparator first trips at code T (T at most all ones) keeps `convDone` at 0 for exactly T+1 cycles.
- R8: `dataOut` is combinational. With `loByteEn` set it shows result bits 7:0. With only `hiByteEn` set it shows result bits 15:8, where bits at or above N read as 0. With neither set it is 0. When both are set the low byte wins.
- R9: The result register keeps its value until the next conversion ends, so it can still be read while a new conversion runs.
- R10: While `convDone` is 1 and no start arrives, the comparator has no effect: `dacCode` and the result stay fixed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| startReq | input | 1 | Host request to begin a conversion |
| cmpHigh | input | 1 | Comparator: 1 when the DAC output has reached the analog input |
| dacCode | output | RES_BITS | Counter value driven to the DAC |
| convDone | output | 1 | 0 while converting, 1 when idle with a valid result |
| hiByteEn | input | 1 | Select the upper result byte onto dataOut |
| loByteEn | input | 1 | Select the lower result byte onto dataOut |
| dataOut | output | 8 | Selected result byte |

## Verification
The start is captured at one edge, so `convDone` falls and `dacCode` reads 0 one cycle after a sampled `startReq`. After that, the k-th busy cycle shows code k. `convDone` rises one edge after the cycle in which the comparator trips or the code is all ones. The result register is loaded at that same edge. `dataOut` follows the byte enables within the same cycle. The bench drives inputs and samples outputs on the falling edge, which lands each check half a period after the edge that produced the value. It counts busy falling edges against T+1 and compares `dacCode` with the running index at every one of them. Byte reads are sampled a short delay after the enables change.

// File: rtl/adc_ramp_pkg.sv
package adc_ramp_pkg;
  typedef struct packed {
    logic clearCnt;
    logic stepCnt;
    logic latchRes;
  } rampStrobe_t;

  typedef enum logic {
    ST_IDLE = 1'b0,
    ST_RAMP = 1'b1
  } rampState_t;
endpackage

// File: rtl/adc_ramp_ctrl.sv
module adc_ramp_ctrl
  import adc_ramp_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        startReq,
  input  logic        cmpHigh,
  input  logic        cntFull,
  output rampStrobe_t strobe,
  output logic        busy
);
  rampState_t state, nextState;

  always_comb begin
    strobe    = '0;
    nextState = state;
    unique case (state)
      ST_IDLE: begin
        if (startReq) begin
          strobe.clearCnt = 1'b1;
          nextState       = ST_RAMP;
        end
      end
      ST_RAMP: begin
        if (cmpHigh || cntFull) begin
          strobe.latchRes = 1'b1;
          nextState       = ST_IDLE;
        end else begin
          strobe.stepCnt = 1'b1;
        end
      end
      default: nextState = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state <= ST_IDLE;
    else        state <= nextState;
  end

  assign busy = (state == ST_RAMP);

  AST_START_TAKEN: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && startReq) |=> busy); // R2
  AST_TRIP_STOPS: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && cmpHigh) |=> !busy); // R4
  AST_FULL_STOPS: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && cntFull) |=> !busy); // R5
  AST_BUSY_NO_RESTART: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> !strobe.clearCnt); // R6
endmodule

// File: rtl/adc_ramp_dp.sv
module adc_ramp_dp
  import adc_ramp_pkg::*;
#(
  parameter int RES_BITS = 10
) (
  input  logic                clk,
  input  logic                rst_n,
  input  rampStrobe_t         strobe,
  input  logic                hiByteEn,
  input  logic                loByteEn,
  output logic [RES_BITS-1:0] cntQ,
  output logic                cntFull,
  output logic [RES_BITS-1:0] resultQ,
  output logic [7:0]          dataOut
);
  localparam int WIDE_BITS = 16;
  localparam int PAD_BITS  = WIDE_BITS - RES_BITS;

  logic [WIDE_BITS-1:0] resWide;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)              cntQ <= '0;
    else if (strobe.clearCnt) cntQ <= '0;
    else if (strobe.stepCnt)  cntQ <= cntQ + RES_BITS'(1);
  end

  assign cntFull = &cntQ;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)               resultQ <= '0;
    else if (strobe.latchRes) resultQ <= cntQ;
  end

  generate
    if (PAD_BITS > 0) begin : g_pad
      assign resWide = {{PAD_BITS{1'b0}}, resultQ};
    end else begin : g_nopad
      assign resWide = resultQ;
    end
  endgenerate

  always_comb begin
    if (loByteEn)      dataOut = resWide[7:0];
    else if (hiByteEn) dataOut = resWide[15:8];
    else               dataOut = 8'h00;
  end

  AST_RESULT_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    !strobe.latchRes |=> $stable(resultQ)); // R9
  AST_NO_ENABLE_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (!loByteEn && !hiByteEn) |-> (dataOut == 8'h00)); // R8
endmodule

// File: rtl/ramp_adc_ctrl.sv
module ramp_adc_ctrl
  import adc_ramp_pkg::*;
#(
  parameter int RES_BITS = 10
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                startReq,
  input  logic                cmpHigh,
  output logic [RES_BITS-1:0] dacCode,
  output logic                convDone,
  input  logic                hiByteEn,
  input  logic                loByteEn,
  output logic [7:0]          dataOut
);
  rampStrobe_t         strobe;
  logic                busy;
  logic                cntFull;
  logic [RES_BITS-1:0] resultQ;

  adc_ramp_ctrl u_ctrl (
    .clk      (clk),
    .rst_n    (rst_n),
    .startReq (startReq),
    .cmpHigh  (cmpHigh),
    .cntFull  (cntFull),
    .strobe   (strobe),
    .busy     (busy)
  );

  adc_ramp_dp #(.RES_BITS(RES_BITS)) u_dp (
    .clk      (clk),
    .rst_n    (rst_n),
    .strobe   (strobe),
    .hiByteEn (hiByteEn),
    .loByteEn (loByteEn),
    .cntQ     (dacCode),
    .cntFull  (cntFull),
    .resultQ  (resultQ),
    .dataOut  (dataOut)
  );

  assign convDone = !busy;

  AST_RAMP_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (!convDone && !cmpHigh && !(&dacCode)) |=> (dacCode == $past(dacCode) + RES_BITS'(1))); // R3
  AST_RESULT_CAPTURE: assert property (@(posedge clk) disable iff (!rst_n)
    (!convDone && (cmpHigh || (&dacCode))) |=> (convDone && resultQ == $past(dacCode))); // R4
  AST_IDLE_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
    (convDone && !startReq) |=> ($stable(dacCode) && convDone)); // R10
endmodule

// File: tb/ramp_adc_ctrl_bench.sv
module ramp_adc_ctrl_bench;
  localparam int CLK_PERIOD = 10;
  localparam int RES_BITS   = 10;
  localparam int FULL       = (1 << RES_BITS) - 1;
  localparam int WATCHDOG   = 50000;

  logic                clk = 1'b0;
  logic                rst_n = 1'b0;
  logic                startReq = 1'b0;
  logic                cmpHigh;
  logic [RES_BITS-1:0] dacCode;
  logic                convDone;
  logic                hiByteEn = 1'b0;
  logic                loByteEn = 1'b0;
  logic [7:0]          dataOut;

  int thr = 1 << 20;
  int nChecks = 0;
  int nFails = 0;
  int cycles = 0;
  bit finished = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  // comparator model: trips once the code reaches the threshold
  always_comb cmpHigh = (int'(dacCode) >= thr);

  ramp_adc_ctrl #(.RES_BITS(RES_BITS)) u_ramp_adc_ctrl (
    .clk(clk), .rst_n(rst_n), .startReq(startReq), .cmpHigh(cmpHigh),
    .dacCode(dacCode), .convDone(convDone),
    .hiByteEn(hiByteEn), .loByteEn(loByteEn), .dataOut(dataOut)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    nChecks++;
    if (!ok) begin
      nFails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic readBytes(input bit lo, input bit hi, output int val);
    @(negedge clk);
    loByteEn = lo;
    hiByteEn = hi;
    #1 val = int'(dataOut);
    loByteEn = 1'b0;
    hiByteEn = 1'b0;
  endtask

  // runs one conversion; returns busy cycles; optional extra start at busy cycle 2
  task automatic runConv(input int threshold, input bit extraStart, output int busyCnt);
    int k;
    int stepErr;
    thr = threshold;
    @(negedge clk);
    startReq = 1'b1;
    @(negedge clk);
    startReq = 1'b0;
    check(convDone == 1'b0, "R2 busy after start", int'(convDone), 0);
    check(dacCode == '0, "R2 code cleared", int'(dacCode), 0);
    k = 0;
    stepErr = 0;
    while (convDone == 1'b0 && k < 70000) begin
      if (int'(dacCode) != k && stepErr == 0) begin
        stepErr = 1;
        check(1'b0, "R3 ramp step", int'(dacCode), k);
      end
      if (extraStart && k == 2) startReq = 1'b1;
      else startReq = 1'b0;
      k++;
      @(negedge clk);
    end
    startReq = 1'b0;
    busyCnt = k;
  endtask

  task automatic testReset;
    int v;
    check(convDone == 1'b1, "R1 idle after reset", int'(convDone), 1);
    check(dacCode == '0, "R1 code zero after reset", int'(dacCode), 0);
    readBytes(1'b1, 1'b0, v);
    check(v == 0, "R1 result zero after reset", v, 0);
  endtask

  task automatic testTrip(input int t);
    int n;
    int v;
    runConv(t, 1'b0, n);
    check(n == t + 1, "R7 busy length", n, t + 1);
    readBytes(1'b1, 1'b0, v);
    check(v == (t & 8'hFF), "R4 low byte of result", v, t & 8'hFF);
    readBytes(1'b0, 1'b1, v);
    check(v == (t >> 8), "R4 high byte of result", v, t >> 8);
  endtask

  task automatic testFullScale(input int t);
    int n;
    int v;
    runConv(t, 1'b0, n);
    check(n == FULL + 1, "R5 full-scale busy length", n, FULL + 1);
    readBytes(1'b1, 1'b0, v);
    check(v == (FULL & 8'hFF), "R5 all-ones low byte", v, FULL & 8'hFF);
    readBytes(1'b0, 1'b1, v);
    check(v == (FULL >> 8), "R5 all-ones high byte", v, FULL >> 8);
  endtask

  task automatic testBusyStart;
    int n;
    int v;
    runConv(40, 1'b1, n);
    check(n == 41, "R6 start while busy keeps duration", n, 41);
    readBytes(1'b1, 1'b0, v);
    check(v == 40, "R6 start while busy keeps result", v, 40);
  endtask

  task automatic testBytes;
    int n;
    int v;
    runConv(677, 1'b0, n);
    readBytes(1'b1, 1'b0, v);
    check(v == 8'hA5, "R8 low byte", v, 8'hA5);
    readBytes(1'b0, 1'b1, v);
    check(v == 8'h02, "R8 high byte zero padded", v, 8'h02);
    readBytes(1'b1, 1'b1, v);
    check(v == 8'hA5, "R8 both enables give low byte", v, 8'hA5);
    readBytes(1'b0, 1'b0, v);
    check(v == 0, "R8 no enable gives zero", v, 0);
  endtask

  task automatic testHoldDuringBusy;
    int v;
    thr = 500;
    @(negedge clk);
    startReq = 1'b1;
    @(negedge clk);
    startReq = 1'b0;
    repeat (5) @(negedge clk);
    check(convDone == 1'b0, "R9 still busy", int'(convDone), 0);
    loByteEn = 1'b1;
    #1 v = int'(dataOut);
    loByteEn = 1'b0;
    check(v == 8'hA5, "R9 old result readable while busy", v, 8'hA5);
    while (convDone == 1'b0) @(negedge clk);
  endtask

  task automatic testIdleIgnoresCmp;
    int codeBefore;
    int v;
    codeBefore = int'(dacCode);
    thr = 0;
    repeat (4) @(negedge clk);
    thr = 1 << 20;
    repeat (3) @(negedge clk);
    check(convDone == 1'b1, "R10 stays idle", int'(convDone), 1);
    check(int'(dacCode) == codeBefore, "R10 code frozen in idle", int'(dacCode), codeBefore);
    readBytes(1'b1, 1'b0, v);
    check(v == (500 & 8'hFF), "R10 result unchanged in idle", v, 500 & 8'hFF);
  endtask

  always @(posedge clk) begin
    cycles <= cycles + 1;
    if (cycles > WATCHDOG && !finished) begin
      nChecks++;
      nFails++;
      $display("FAIL watchdog actual=%0d expected=%0d", cycles, WATCHDOG);
      $display("%0d/%0d checks passed", nChecks - nFails, nChecks);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    testReset();
    testTrip(0);
    testTrip(5);
    testTrip(300);
    testTrip(FULL);
    testFullScale(FULL + 1);
    testFullScale(5000);
    testBusyStart();
    testBytes();
    testHoldDuringBusy();
    testIdleIgnoresCmp();
    finished = 1'b1;
    $display("%0d/%0d checks passed", nChecks - nFails, nChecks);
    $finish;
  end
endmodule